// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Bus Hand-Off

This block takes service requests from up to four peripheral channels, picks one, and manages the transfer of bus ownership from the processor. The request lines are asynchronous, so each one is synchronized before it is used. When an enabled request is waiting, the block raises a hold request toward the processor. It then waits for the hold acknowledge. When the acknowledge arrives it latches a winning channel and asserts that channel's acknowledge line. It keeps this grant until the datapath signals end of transfer, and then gives the bus back.

Channel ranking follows one of two modes, chosen by an input. In fixed mode, channel 0 always outranks channel 1, which outranks channel 2, which outranks channel 3. In rotating mode, the channel that was just served drops to the bottom of the order and its circular successor moves to the top. A channel enable mask is written through a load strobe and is cleared by reset. A request on a disabled channel takes no part in arbitration.

Top module: `dma_arbiter`

## Requirements
- R1: After reset, `hrq` is low, `dack` is 4'b0000, and the enable mask is all zero. While the mask is zero, no request raises `hrq`.
- R2: Each `dreq` bit passes through a two-stage synchronizer. A request that appears between edges, in an idle block, raises `hrq` after the third rising edge and not before.
- R3: A request whose bit in the enable mask is 0 is ignored. It neither raises `hrq` nor wins a grant. The mask is written from `mask_val` on an edge where `mask_ld` is 1.
- R4: While `hrq` is high and `hlda` is low, `dack` stays 4'b0000, however long the wait lasts.
- R5: When `rotate_en` is 0, the lowest-numbered enabled pending request wins. Bit i of `dack` corresponds to channel i.
- R6: When `rotate_en` is 1, the channel after the one last served, counted modulo four, ranks highest, and the served channel ranks lowest. Out of reset the top rank belongs to channel 0. The top rank also returns to channel 0 after any transfer that finishes in fixed mode.
- R7: In rotating mode, the search runs in circular order from the top rank and passes over channels that are masked or idle.
- R8: The winner is latched on the edge that samples `hlda` high. It stays unchanged until end of transfer, even if a higher-ranked request arrives or the original request goes away.
- R9: `dack` is nonzero only while both `hrq` and `hlda` are high. If `hlda` drops during a grant, `dack` drops in the same cycle. It returns when `hlda` does.
- R10: The rising edge that samples `eot` high during a grant drops `hrq` and `dack`. The rotation point is updated on that same edge, so a request still pending afterwards is arbitrated under the new order.
- R11: At most one `dack` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dreq | input | 4 | Asynchronous per-channel service requests |
| mask_ld | input | 1 | Load strobe for the enable mask |
| mask_val | input | 4 | New enable mask value, 1 = channel enabled |
| rotate_en | input | 1 | 1 = rotating ranking, 0 = fixed ranking |
| hlda | input | 1 | Hold acknowledge from the processor |
| eot | input | 1 | End-of-transfer pulse from the datapath |
| hrq | output | 1 | Hold request to the processor |
| dack | output | 4 | One-hot channel acknowledge |

## Verification
The case that needs the most care is a bus release and a new arbitration falling on the same edge. The edge that ends a transfer also moves the rotation point, while another enabled request is already waiting in the synchronizer. The bench provokes this by keeping requests on channels 0 and 1 pending while channel 0 is served in rotating mode, and pulsing `eot` with both still asserted. It then checks three things: `hrq` falls on that edge, `hrq` rises again on the next edge, and the new grant goes to channel 1 rather than channel 0. A second overlap is also exercised. A higher-ranked request arrives during a live grant, and the bench checks that the latched acknowledge does not move.

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH  = 4,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  input  logic           mask_ld,
  input  logic [NCH-1:0] mask_val,
  input  logic           rotate_en,
  input  logic           hlda,
  input  logic           eot,
  output logic           hrq,
  output logic [NCH-1:0] dack
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GRANT} st_t;

  st_t                       st;
  logic [SYNC-1:0][NCH-1:0]  sq;
  logic [NCH-1:0]            en;
  logic [IW-1:0]             top;
  logic [IW-1:0]             win;
  logic [IW-1:0]             pick;
  logic [IW-1:0]             base;
  logic [NCH-1:0]            req;
  logic                      any;

  assign req  = sq[SYNC-1] & en;
  assign any  = |req;
  assign base = rotate_en ? top : '0;
  assign hrq  = (st != S_IDLE);
  assign dack = (st == S_GRANT && hlda) ? (NCH'(1) << win) : '0;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++) begin
      int j;
      j = (int'(base) + k) % NCH;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= {sq[SYNC-2:0], dreq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= '0;
    else if (mask_ld) en <= mask_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      win <= '0;
      top <= '0;
    end else begin
      case (st)
        S_IDLE:  if (any) st <= S_WAIT;
        S_WAIT: begin
          if (!any) st <= S_IDLE;
          else if (hlda) begin
            st  <= S_GRANT;
            win <= pick;
          end
        end
        S_GRANT: if (eot) begin
          st  <= S_IDLE;
          top <= rotate_en ? IW'((int'(win) + 1) % NCH) : '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  one_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R9
  dack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != '0) |-> (hrq && hlda));

  // R4
  no_early_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hrq && !hlda) |-> (dack == '0));

  // R8
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRANT && !eot) |=> (st == S_GRANT && $stable(win)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRANT && eot) |=> (!hrq && dack == '0));

  // R3
  masked_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && hlda && any) |-> en[pick]);

endmodule

// File: tb/sim_dma_arbiter.sv
module sim_dma_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dreq = '0;
  logic       mask_ld = 1'b0;
  logic [3:0] mask_val = '0;
  logic       rotate_en = 1'b0;
  logic       hlda = 1'b0;
  logic       eot = 1'b0;
  logic       hrq;
  logic [3:0] dack;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .mask_ld(mask_ld),
    .mask_val(mask_val), .rotate_en(rotate_en), .hlda(hlda),
    .eot(eot), .hrq(hrq), .dack(dack)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic set_mask(input logic [3:0] m);
    mask_val = m; mask_ld = 1'b1; step(); mask_ld = 1'b0;
  endtask

  task automatic flush();
    dreq = '0; repeat (4) step();
  endtask

  task automatic serve(input string rq, input logic [3:0] req, input int ch);
    dreq = req;
    for (int i = 0; i < 8 && !hrq; i++) step();
    chk(rq, {3'b0, hrq}, 4'b0001);
    chk("R4", dack, 4'b0000);
    hlda = 1'b1; step();
    chk(rq, dack, 4'b0001 << ch);
    dreq = '0; repeat (3) step();
    eot = 1'b1; step(); eot = 1'b0;
    chk("R10", {3'b0, hrq}, 4'b0000);
    chk("R10", dack, 4'b0000);
    hlda = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R1", {3'b0, hrq}, 4'b0000);
    chk("R1", dack, 4'b0000);
    dreq = 4'b1111; repeat (6) step();
    chk("R1", {3'b0, hrq}, 4'b0000);
    flush();
  endtask

  task automatic t_mask();
    set_mask(4'b1110);
    dreq = 4'b0001; repeat (6) step();
    chk("R3", {3'b0, hrq}, 4'b0000);
    flush();
    set_mask(4'b1010);
    serve("R3", 4'b0111, 1);
  endtask

  task automatic t_sync();
    set_mask(4'b1111);
    flush();
    dreq = 4'b0100;
    step(); chk("R2", {3'b0, hrq}, 4'b0000);
    step(); chk("R2", {3'b0, hrq}, 4'b0000);
    step(); chk("R2", {3'b0, hrq}, 4'b0001);
    hlda = 1'b1; step();
    chk("R2", dack, 4'b0100);
    dreq = '0; repeat (3) step();
    eot = 1'b1; step(); eot = 1'b0; hlda = 1'b0; step();
  endtask

  task automatic t_wait();
    dreq = 4'b0010;
    repeat (4) step();
    for (int i = 0; i < 5; i++) step();
    chk("R4", {3'b0, hrq}, 4'b0001);
    chk("R4", dack, 4'b0000);
    hlda = 1'b1; step();
    chk("R4", dack, 4'b0010);
    hlda = 1'b0; #1;
    chk("R9", dack, 4'b0000);
    chk("R9", {3'b0, hrq}, 4'b0001);
    step(); hlda = 1'b1; #1;
    chk("R9", dack, 4'b0010);
    dreq = '0; repeat (3) step();
    eot = 1'b1; step(); eot = 1'b0; hlda = 1'b0; step();
  endtask

  task automatic t_fixed();
    rotate_en = 1'b0;
    serve("R5", 4'b1010, 1);
    serve("R5", 4'b1100, 2);
    serve("R5", 4'b1000, 3);
    serve("R5", 4'b1111, 0);
  endtask

  task automatic t_hold();
    dreq = 4'b1000;
    repeat (4) step();
    hlda = 1'b1; step();
    chk("R8", dack, 4'b1000);
    dreq = 4'b1001; repeat (5) step();
    chk("R8", dack, 4'b1000);
    dreq = '0; repeat (3) step();
    chk("R8", dack, 4'b1000);
    eot = 1'b1; step(); eot = 1'b0; hlda = 1'b0; step();
  endtask

  task automatic t_rotate();
    rotate_en = 1'b1;
    serve("R6", 4'b1111, 0);
    serve("R6", 4'b1111, 1);
    serve("R6", 4'b1111, 2);
    serve("R6", 4'b1111, 3);
    serve("R7", 4'b0101, 0);
    serve("R7", 4'b0101, 2);
    set_mask(4'b1011);
    serve("R7", 4'b1111, 3);
    serve("R7", 4'b0110, 1);
    set_mask(4'b1111);
  endtask

  task automatic t_eot_overlap();
    rotate_en = 1'b1;
    serve("R6", 4'b1000, 3);
    dreq = 4'b0011;
    repeat (4) step();
    hlda = 1'b1; step();
    chk("R10", dack, 4'b0001);
    eot = 1'b1; step(); eot = 1'b0;
    chk("R10", {3'b0, hrq}, 4'b0000);
    step();
    chk("R10", {3'b0, hrq}, 4'b0001);
    step();
    chk("R10", dack, 4'b0010);
    dreq = '0; repeat (3) step();
    eot = 1'b1; step(); eot = 1'b0; hlda = 1'b0; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_mask();
    t_sync();
    t_wait();
    t_fixed();
    t_hold();
    t_rotate();
    t_eot_overlap();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule